// File: doc/BRIEF.md
# NAND Page Read/Program Sequencer

This block is a hardware state machine that moves one 512-byte main-area page between a host and an 8-bit small-page NAND flash device. The host supplies a 17-bit page number (the byte address shifted right by nine), an operation select and a one-clock start strobe. The sequencer then takes the flash through the whole transaction: it enables the chip, latches a command byte, latches four address bytes, waits on the ready/busy line, and streams the data bytes. For a program it also latches the confirm command and waits for the device to finish. It then releases the chip.

Data moves over two byte streams with valid/ready handshakes, one per direction. On the flash side every latched byte gets a write-enable pulse whose low and high phases last a parameterized number of clocks. Read bytes are captured at the rising edge of read-enable. The flash uses a 528-byte page split into two 256-byte halves. The half is chosen by the opcode rather than by an address bit, so a full-page read always starts with the first-half read opcode and a column of zero.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, and whenever no operation is running, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_dq_oe are 0, and busy, done and rd_valid are 0.
- R2: Chip enable goes low before the first write-enable pulse and stays low on every latched byte. The first latched byte has nand_cle=1 and nand_ale=0 and carries 0x00 for a read (op_prog=0) or 0x80 for a program (op_prog=1).
- R3: Exactly four address bytes follow the command, each latched with nand_ale=1 and nand_cle=0, in this order: 0x00, page_num[7:0], page_num[15:8], {7'b0, page_num[16]}.
- R4: Each nand_we_n low phase lasts exactly WE_LO clocks, and every two low phases are separated by at least WE_HI clocks high. A byte is latched at the rising edge of nand_we_n.
- R5: A read issues no read-enable pulse before nand_rb (1 = ready) is high after the address bytes. nand_dq_oe is 0 whenever nand_re_n is low.
- R6: A read captures PAGE_BYTES bytes, each at a rising edge of nand_re_n after exactly RE_LO clocks low. The bytes are delivered in order on rd_data with rd_valid held until rd_ready. No new read-enable pulse starts while a byte is still unaccepted.
- R7: A program takes PAGE_BYTES bytes from wr_data in order through the wr_valid/wr_ready handshake. Each is latched with nand_cle=0 and nand_ale=0. A final byte 0x10 is then latched with nand_cle=1 and nand_ale=0.
- R8: After the confirm byte, done is not raised until nand_rb has gone low and then high again.
- R9: done is high for exactly one clock, with chip enable released in that same clock. The block is idle the next clock.
- R10: If nand_rb stays low for BUSY_TIMEOUT clocks in a wait, the operation ends with done=1 and err=1. A normal completion gives err=0.
- R11: A start received while busy is ignored. The running operation keeps its own opcode and page, and no second operation follows.
- R12: nand_cle and nand_ale are never high together, and nand_we_n and nand_re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to begin an operation |
| op_prog | input | 1 | 1 = program page, 0 = read page |
| page_num | input | 17 | Page number (byte address >> 9) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Valid with done: ready/busy timeout |
| wr_data | input | 8 | Program byte from host |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Sequencer takes the program byte |
| rd_data | output | 8 | Byte read from flash |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus, outgoing value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus, incoming value |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
Two events can coincide in one clock. The host's acceptance of a read byte can land in the same cycle in which the sequencer decides whether to launch the next read-enable pulse. A start request can also arrive while a transfer is running. The first case is provoked by toggling rd_ready at random on every clock. It is judged by comparing every delivered byte and its order with the flash model's pattern, and by the exact read-enable low width. The second case is provoked by pulsing start with the opposite opcode and an inverted page in the middle of a read. It is judged by the latched command and address log, and by a single done pulse.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int PG_W = 17;

   localparam logic [7:0] OPC_READ  = 8'h00;
   localparam logic [7:0] OPC_PROG  = 8'h80;
   localparam logic [7:0] OPC_CONF  = 8'h10;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_CEN, SQ_CMD, SQ_ADDR, SQ_RWAIT, SQ_RDATA,
      SQ_WDATA, SQ_CONF, SQ_PLO, SQ_PHI, SQ_DONE
   } sq_state_t;

   // address byte for cycle idx of a full-page access (column = 0)
   function automatic logic [7:0] addr_byte(input logic [1:0] idx,
                                            input logic [PG_W-1:0] pg);
      logic [7:0] b;
      case (idx)
         2'd0:    b = 8'h00;
         2'd1:    b = pg[7:0];
         2'd2:    b = pg[15:8];
         default: b = {7'b0, pg[16]};
      endcase
      return b;
   endfunction

endpackage

// File: rtl/nand_strobe_tmr.sv
module nand_strobe_tmr #(
   parameter int LO = 2,
   parameter int HI = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic active,
   output logic rise,
   output logic fin,
   output logic busy
);
   localparam int TOT = LO + HI;
   localparam int CW  = $clog2(TOT + 1);

   if (LO < 1 || HI < 1) begin : g_bad_phase
      $error("strobe phases must each be at least one clock");
   end

   logic          run;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         if (go) begin
            run <= 1'b1;
            cnt <= '0;
         end
      end else if (cnt == CW'(TOT - 1)) begin
         run <= 1'b0;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign active = run && (cnt < CW'(LO));
   assign rise   = run && (cnt == CW'(LO - 1));
   assign fin    = run && (cnt == CW'(TOT - 1));
   assign busy   = run;

   // R4: a launched pulse drives the strobe low on the next clock
   a_r4_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !run) |=> active);
   // R4: after the last low clock the strobe is high
   a_r4_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !active);

endmodule

// File: rtl/nand_byte_ctr.sv
module nand_byte_ctr #(
   parameter int COUNT = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);
   localparam int  BW   = $clog2(COUNT + 1);
   localparam bit  POW2 = (COUNT & (COUNT - 1)) == 0;

   if (COUNT < 1) begin : g_bad_count
      $error("page byte count must be positive");
   end

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (inc && !full)   cnt <= cnt + 1'b1;
   end

   if (POW2) begin : g_pow2
      assign full = cnt[BW-1];
   end else begin : g_cmp
      assign full = (cnt == BW'(COUNT));
   end

endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
   import nand_seq_pkg::*;
#(
   parameter int PAGE_BYTES   = 512,
   parameter int WE_LO        = 2,
   parameter int WE_HI        = 2,
   parameter int RE_LO        = 2,
   parameter int RE_HI        = 1,
   parameter int SETTLE       = 4,
   parameter int BUSY_TIMEOUT = 1024
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            op_prog,
   input  logic [PG_W-1:0] page_num,
   output logic            busy,
   output logic            done,
   output logic            err,
   input  logic [7:0]      wr_data,
   input  logic            wr_valid,
   output logic            wr_ready,
   output logic [7:0]      rd_data,
   output logic            rd_valid,
   input  logic            rd_ready,
   output logic            nand_ce_n,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [7:0]      nand_dq_o,
   output logic            nand_dq_oe,
   input  logic [7:0]      nand_dq_i,
   input  logic            nand_rb
);
   localparam int TW = $clog2(BUSY_TIMEOUT + 1);

   if (SETTLE < 1 || SETTLE >= BUSY_TIMEOUT) begin : g_bad_wait
      $error("SETTLE must lie between 1 and BUSY_TIMEOUT-1");
   end

   sq_state_t       st, st_n;
   logic            op_q, err_q, rdv_q, tmo;
   logic [PG_W-1:0] page_q;
   logic [1:0]      aidx;
   logic [7:0]      dq_q, dq_n, rdd_q;
   logic [TW-1:0]   wcnt;
   logic            we_go, we_act, we_rise, we_fin, we_busy;
   logic            re_go, re_act, re_rise, re_fin, re_busy;
   logic            full;

   nand_strobe_tmr #(.LO(WE_LO), .HI(WE_HI)) u_we (
      .clk(clk), .rst_n(rst_n), .go(we_go),
      .active(we_act), .rise(we_rise), .fin(we_fin), .busy(we_busy));

   nand_strobe_tmr #(.LO(RE_LO), .HI(RE_HI)) u_re (
      .clk(clk), .rst_n(rst_n), .go(re_go),
      .active(re_act), .rise(re_rise), .fin(re_fin), .busy(re_busy));

   nand_byte_ctr #(.COUNT(PAGE_BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(st == SQ_IDLE),
      .inc((wr_valid && wr_ready) || re_rise), .full(full));

   always_comb begin
      st_n     = st;
      we_go    = 1'b0;
      re_go    = 1'b0;
      wr_ready = 1'b0;
      dq_n     = dq_q;
      tmo      = 1'b0;
      unique case (st)
         SQ_IDLE:  if (start) st_n = SQ_CEN;
         SQ_CEN:   st_n = SQ_CMD;
         SQ_CMD: begin
            we_go = !we_busy;
            dq_n  = op_q ? OPC_PROG : OPC_READ;
            if (we_fin) st_n = SQ_ADDR;
         end
         SQ_ADDR: begin
            we_go = !we_busy;
            dq_n  = addr_byte(aidx, page_q);
            if (we_fin && aidx == 2'd3) st_n = op_q ? SQ_WDATA : SQ_RWAIT;
         end
         SQ_RWAIT: begin
            if (wcnt >= TW'(SETTLE) && nand_rb) st_n = SQ_RDATA;
            else if (wcnt == TW'(BUSY_TIMEOUT)) begin st_n = SQ_DONE; tmo = 1'b1; end
         end
         SQ_RDATA: begin
            re_go = !re_busy && !rdv_q && !full;
            if (full && !re_busy && !rdv_q) st_n = SQ_DONE;
         end
         SQ_WDATA: begin
            wr_ready = !we_busy && !full;
            we_go    = wr_valid && wr_ready;
            dq_n     = wr_data;
            if (full && !we_busy) st_n = SQ_CONF;
         end
         SQ_CONF: begin
            we_go = !we_busy;
            dq_n  = OPC_CONF;
            if (we_fin) st_n = SQ_PLO;
         end
         SQ_PLO: begin
            if (!nand_rb) st_n = SQ_PHI;
            else if (wcnt == TW'(BUSY_TIMEOUT)) begin st_n = SQ_DONE; tmo = 1'b1; end
         end
         SQ_PHI: begin
            if (nand_rb) st_n = SQ_DONE;
            else if (wcnt == TW'(BUSY_TIMEOUT)) begin st_n = SQ_DONE; tmo = 1'b1; end
         end
         SQ_DONE:  st_n = SQ_IDLE;
         default:  st_n = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         op_q   <= 1'b0;
         page_q <= '0;
         err_q  <= 1'b0;
         aidx   <= 2'd0;
         wcnt   <= '0;
         dq_q   <= 8'h00;
         rdv_q  <= 1'b0;
         rdd_q  <= 8'h00;
      end else begin
         st <= st_n;
         if (st == SQ_IDLE && start) begin
            op_q   <= op_prog;
            page_q <= page_num;
            err_q  <= 1'b0;
         end else if (tmo) begin
            err_q  <= 1'b1;
         end
         if (st == SQ_IDLE)                 aidx <= 2'd0;
         else if (st == SQ_ADDR && we_fin)  aidx <= aidx + 2'd1;
         if (st_n != st)                          wcnt <= '0;
         else if (wcnt != TW'(BUSY_TIMEOUT))      wcnt <= wcnt + 1'b1;
         if (we_go) dq_q <= dq_n;
         if (re_rise) begin
            rdd_q <= nand_dq_i;
            rdv_q <= 1'b1;
         end else if (rdv_q && rd_ready) begin
            rdv_q <= 1'b0;
         end
      end
   end

   assign busy       = (st != SQ_IDLE);
   assign done       = (st == SQ_DONE);
   assign err        = done && err_q;
   assign rd_valid   = rdv_q;
   assign rd_data    = rdd_q;
   assign nand_ce_n  = (st == SQ_IDLE) || (st == SQ_DONE);
   assign nand_cle   = (st == SQ_CMD) || (st == SQ_CONF);
   assign nand_ale   = (st == SQ_ADDR);
   assign nand_we_n  = !we_act;
   assign nand_re_n  = !re_act;
   assign nand_dq_o  = dq_q;
   assign nand_dq_oe = (st == SQ_CMD) || (st == SQ_ADDR) ||
                       (st == SQ_WDATA) || (st == SQ_CONF);

   // R12: latch enables exclusive, read and write strobes exclusive
   a_r12_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));
   // R1: idle means every flash strobe inactive
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe));
   // R2: no byte latched without chip enable
   a_r2_ce_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> !nand_ce_n);
   // R5: bus released while the flash drives it
   a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);
   // R6: a presented byte is held until taken
   a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
   // R6: read strobe high after its final clock
   a_r6_re_end: assert property (@(posedge clk) disable iff (!rst_n)
      re_fin |=> nand_re_n);
   // R4: write strobe high after its rising clock
   a_r4_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      we_rise |=> nand_we_n);
   // R9: done lasts one clock and leads to idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R11: a start during an operation leaves its page and opcode alone
   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> ($stable(page_q) && $stable(op_q)));

endmodule

// File: tb/tb_nand_page_seq.sv
module tb_nand_page_seq;
   localparam int WL = 2, WH = 2, RL = 3, RH = 1, SET = 4, TMO = 600, NB = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        start = 1'b0, op_prog = 1'b0;
   logic [16:0] page_num = '0;
   logic        busy, done, err;
   logic [7:0]  wr_data = 8'h00;
   logic        wr_valid = 1'b0, wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid, rd_ready = 1'b0;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = 8'h00;
   logic        nand_rb = 1'b1;

   nand_page_seq #(.PAGE_BYTES(NB), .WE_LO(WL), .WE_HI(WH), .RE_LO(RL), .RE_HI(RH),
                   .SETTLE(SET), .BUSY_TIMEOUT(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .page_num(page_num),
      .busy(busy), .done(done), .err(err),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb));

   int n_chk = 0, n_bad = 0;

   function automatic logic [7:0] rd_pat(input logic [16:0] pg, input int i);
      return 8'((int'(pg) * 7) + (i * 13) + (i >> 8));
   endfunction
   function automatic logic [7:0] wr_pat(input logic [16:0] pg, input int i);
      return 8'(int'(pg[7:0]) ^ (i * 29) ^ 165);
   endfunction
   function automatic logic [7:0] exp_addr(input int i, input logic [16:0] pg);
      if (i == 0) return 8'h00;
      if (i == 1) return pg[7:0];
      if (i == 2) return pg[15:8];
      return {7'b0, pg[16]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // flash model and host agents, all acting at the falling edge
   logic [9:0]  lg [0:599];
   int          lg_n, rd_idx, rd_got, rd_bad, rd_bad_act, rd_bad_exp, wr_idx;
   int          we_low, we_high, re_low, width_bad, ce_bad, excl_bad, rb_bad, oe_bad;
   int          done_cnt, rb_cnt;
   bit          err_seen, rb_at_done, stuck, cur_op;
   logic [16:0] cur_page;
   logic        prev_we = 1'b1, prev_re = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!nand_we_n) begin
            if (prev_we && we_high < WH) width_bad++;
            we_low++;
            we_high = 0;
         end else begin
            we_high++;
            if (!prev_we) begin
               if (we_low != WL) width_bad++;
               we_low = 0;
               if (nand_ce_n) ce_bad++;
               if (lg_n < 600) lg[lg_n] = {nand_cle, nand_ale, nand_dq_o};
               lg_n++;
               if (!cur_op && lg_n == 5) begin
                  nand_rb = 1'b0; rb_cnt = 8 + int'($urandom % 24);
               end
               if (nand_cle && !nand_ale && nand_dq_o == 8'h10) begin
                  nand_rb = 1'b0; rb_cnt = 8 + int'($urandom % 24);
               end
            end
         end
         if (!nand_re_n) begin
            re_low++;
            if (!nand_rb) rb_bad++;
            if (nand_dq_oe) oe_bad++;
         end else if (!prev_re) begin
            if (re_low != RL) width_bad++;
            re_low = 0;
            rd_idx++;
         end
         nand_dq_i = rd_pat(cur_page, rd_idx);
         if (nand_cle && nand_ale) excl_bad++;
         if (!nand_we_n && !nand_re_n) excl_bad++;
         if (!nand_rb && !stuck) begin
            if (rb_cnt == 0) nand_rb = 1'b1;
            else rb_cnt--;
         end
         rd_ready = ($urandom % 4) != 0;
         if (rd_valid && rd_ready) begin
            if (rd_data != rd_pat(cur_page, rd_got) && rd_bad == 0) begin
               rd_bad_act = int'(rd_data); rd_bad_exp = int'(rd_pat(cur_page, rd_got));
            end
            if (rd_data != rd_pat(cur_page, rd_got)) rd_bad++;
            rd_got++;
         end
         if (cur_op && wr_idx < NB) begin
            wr_valid = ($urandom % 3) != 0;
            wr_data  = wr_pat(cur_page, wr_idx);
         end else begin
            wr_valid = 1'b0;
         end
         if (wr_valid && wr_ready) wr_idx++;
         if (done) begin
            done_cnt++;
            err_seen   = err;
            rb_at_done = nand_rb;
         end
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
   end

   task automatic run_op(input bit prog, input logic [16:0] pg, input bit stk, input bit intrude);
      int guard;
      int dbad;
      @(negedge clk); #1;
      lg_n = 0; rd_idx = 0; rd_got = 0; rd_bad = 0; wr_idx = 0; done_cnt = 0;
      width_bad = 0; ce_bad = 0; excl_bad = 0; rb_bad = 0; oe_bad = 0;
      stuck = stk; cur_op = prog; cur_page = pg;
      start = 1'b1; op_prog = prog; page_num = pg;
      guard = 0;
      while (done_cnt == 0 && guard < 20000) begin
         @(negedge clk); #1;
         guard++;
         if (intrude && guard == 40) begin
            start = 1'b1; op_prog = ~prog; page_num = ~pg;
         end else begin
            start = 1'b0; page_num = 17'($urandom);
         end
      end
      chk(guard < 20000, "R9", "watchdog on done", guard, 0);
      repeat (20) begin @(negedge clk); #1; end
      stuck = 1'b0;
      // R9 / R11: exactly one done, then idle with the bus released
      chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
      chk(!busy && nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe,
          "R1", "idle after operation", int'(busy), 0);
      // R10
      chk(err_seen == stk, "R10", "err at done", int'(err_seen), int'(stk));
      // R2 / R3 / R7 / R11: latched byte log
      chk(lg_n == (prog ? NB + 6 : 5), "R11", "latched byte count", lg_n, prog ? NB + 6 : 5);
      chk(lg[0] == {2'b10, prog ? 8'h80 : 8'h00}, "R2", "command byte", int'(lg[0]),
          int'({2'b10, prog ? 8'h80 : 8'h00}));
      for (int i = 0; i < 4; i++)
         chk(lg[1 + i] == {2'b01, exp_addr(i, pg)}, "R3", $sformatf("address cycle %0d", i),
             int'(lg[1 + i]), int'({2'b01, exp_addr(i, pg)}));
      if (prog) begin
         dbad = 0;
         for (int i = 0; i < NB; i++)
            if (lg[5 + i] != {2'b00, wr_pat(pg, i)}) dbad++;
         chk(dbad == 0, "R7", "program data mismatches", dbad, 0);
         chk(lg[NB + 5] == 10'h210, "R7", "confirm byte", int'(lg[NB + 5]), 'h210);
         if (!stk) chk(rb_at_done, "R8", "ready at done", int'(rb_at_done), 1);
      end else begin
         chk(rd_got == NB, "R6", "bytes delivered", rd_got, NB);
         chk(rd_bad == 0, "R6", "read byte value", rd_bad_act, rd_bad_exp);
      end
      chk(width_bad == 0, "R4", "strobe phase violations", width_bad, 0);
      chk(ce_bad == 0, "R2", "bytes latched without chip enable", ce_bad, 0);
      chk(excl_bad == 0, "R12", "strobe overlaps", excl_bad, 0);
      chk(rb_bad == 0 && oe_bad == 0, "R5", "read while busy or bus driven", rb_bad + oe_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe &&
          !busy && !done && !rd_valid, "R1", "reset state", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(!busy && nand_ce_n, "R1", "idle after reset", int'(busy), 0);
      $urandom(32'd1234);
      run_op(1'b0, 17'h00000, 1'b0, 1'b0);
      run_op(1'b1, 17'h1FFFF, 1'b0, 1'b0);
      run_op(1'b0, 17'h1FFFF, 1'b0, 1'b0);
      run_op(1'b1, 17'h0A5C3, 1'b1, 1'b0);   // R10: flash never leaves busy
      run_op(1'b0, 17'h13579, 1'b0, 1'b1);   // R11: start during a read
      for (int k = 0; k < 8; k++)
         run_op(bit'($urandom % 2), 17'($urandom), 1'b0, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL R9 global watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule